// File: doc/BRIEF.md
# Channelized HDLC Receive Controller

This block pulls HDLC frames out of a serial line. The line is organized in repeating frames of time slots, with eight bits in each slot. A frame marker restarts a bit/slot position counter. Only one configured slot carries the data link. Within that slot, a per-position skip mask removes the bits that belong to other traffic. The remaining bits go to a deframer. The deframer synchronizes on flags, strips inserted zeros, assembles bytes, checks the frame check sequence and detects aborts.

Payload bytes are written into a receive FIFO. The two check-sequence bytes are not stored. The last payload byte of a frame is tagged with an end marker and a bad flag. The host pops entries through a simple read port. It sees a live count of stored bytes, real-time empty/full flags, and sticky event bits. The event bits are cleared by write-one pulses and are combined into one interrupt under a per-bit enable mask.

Top module: `hdlc_slot_rx`

## Requirements
- R1: A line bit reaches the deframer only when `line_en` is high, the slot counter equals `cfg_slot`, and `cfg_skip[k]` is 0. Here k is the bit's position 0..7 within the slot, counted from the first bit after `line_sync`. All other line bits have no effect.
- R2: The flag 0x7E aligns the byte boundary. Data is received least significant bit first. Consecutive flags between frames are accepted.
- R3: A zero that follows five consecutive ones is discarded, so payload containing 0xFF or 0x7E is recovered unchanged.
- R4: Seven consecutive ones inside a frame abort it and set `ev_status[2]`. If bytes of that frame are already stored, the last stored byte carries `rd_last=1`, `rd_bad=1`. `rx_active` then falls until the next flag.
- R5: For a frame whose check sequence is correct, every payload byte is stored in order. The last one carries `rd_last=1`, `rd_bad=0`, the 2 check bytes are not stored, and `ev_status[0]` is set.
- R6: The frame is marked bad when its CRC-16 (polynomial 0x1021 bit-reversed, preset 0xFFFF, residue 0xF0B8) fails or its length is not a whole number of bytes. Its last stored byte then has `rd_last=1`, `rd_bad=1`, and `ev_status[1]` is set.
- R7: A frame of fewer than 4 bytes between flags (check bytes included) leaves no FIFO entry and sets no event bit.
- R8: The FIFO holds 64 entries. `avail` equals the number of stored entries and drops by one per `rd_pop`. `fifo_empty` and `fifo_full` follow it.
- R9: A write into a full FIFO sets the sticky `ev_status[3]`. Every later byte of that frame is dropped, including its end marker.
- R10: Event bits stay set until a 1 on the matching `ev_clear` bit. `irq` is high exactly when a set event bit has its `ev_int_en` bit set.
- R11: After reset the FIFO is empty, `avail` is 0, all event bits are 0, and `irq` and `rx_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_en | input | 1 | A line bit is present this cycle |
| line_sync | input | 1 | Present bit is bit 0 of slot 0 |
| line_bit | input | 1 | Serial line data |
| cfg_slot | input | 5 | Slot carrying the data link |
| cfg_skip | input | 8 | 1 = bit position not used by the link |
| rd_pop | input | 1 | Remove head entry |
| rd_data | output | 8 | Head entry byte |
| rd_last | output | 1 | Head entry ends a frame |
| rd_bad | output | 1 | Frame ended by bad CRC, misalignment or abort |
| avail | output | 7 | Stored entries |
| fifo_empty | output | 1 | No entry stored |
| fifo_full | output | 1 | All entries used |
| rx_active | output | 1 | Deframer is flag-synchronized |
| ev_status | output | 4 | Sticky events: 0 good end, 1 bad end, 2 abort, 3 overrun |
| ev_clear | input | 4 | Write-one clear of event bits |
| ev_int_en | input | 4 | Interrupt enable per event bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives frames into different slots under sparse skip masks. It fills the skipped positions with a changing pattern, so a mis-counted position would show up as corrupted bytes or CRC failures. Payloads with runs of ones exercise zero removal. A wrong stuffing rule would either lose bits or report false aborts. Separate frames test:
- a corrupted check sequence;
- three stray bits before the closing flag;
- a three-byte frame;
- an abort after six bytes, where the 7-bit look-behind leaves the last byte incomplete.

A design that mishandles these stores bytes for a runt, or marks the wrong entry as the last one. A 70-byte frame overruns the FIFO. A design that keeps writing after the overrun, or stores the end marker, shows a wrong count or wrong data.

// File: rtl/hdlc_slot_rx.sv
module hdlc_slot_rx #(
  parameter int NUM_SLOTS = 32,
  parameter int DEPTH     = 64,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_en,
  input  logic          line_sync,
  input  logic          line_bit,
  input  logic [SW-1:0] cfg_slot,
  input  logic [7:0]    cfg_skip,
  input  logic          rd_pop,
  output logic [7:0]    rd_data,
  output logic          rd_last,
  output logic          rd_bad,
  output logic [AW:0]   avail,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          rx_active,
  output logic [3:0]    ev_status,
  input  logic [3:0]    ev_clear,
  input  logic [3:0]    ev_int_en,
  output logic          irq
);
  localparam logic [15:0] RESIDUE = 16'hF0B8;
  localparam logic [15:0] POLY_R  = 16'h8408;

  // position within the line frame
  logic [2:0]    bit_pos;
  logic [SW-1:0] slot_pos;
  wire [2:0]    cur_bit  = line_sync ? 3'd0 : bit_pos;
  wire [SW-1:0] cur_slot = line_sync ? '0 : slot_pos;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_pos  <= '0;
      slot_pos <= '0;
    end else if (line_en) begin
      bit_pos <= cur_bit + 3'd1;
      if (cur_bit == 3'd7)
        slot_pos <= (cur_slot == SW'(NUM_SLOTS - 1)) ? '0 : cur_slot + 1'b1;
      else
        slot_pos <= cur_slot;
    end

  wire tap = line_en && (cur_slot == cfg_slot) && !cfg_skip[cur_bit];

  // deframer state
  logic [2:0]  ones, fill, bcnt, nbytes;
  logic        in_frame, drop;
  logic [6:0]  dl, acc;
  logic [15:0] crc;
  logic [7:0]  h0, h1, h2;

  wire stuff = tap && !line_bit && ones == 3'd5;
  wire flag  = tap && !line_bit && ones == 3'd6;
  wire abrt  = tap &&  line_bit && ones == 3'd6;
  wire dbit  = tap && in_frame && !stuff && !flag && !abrt;
  wire shout = dbit && fill == 3'd7;
  wire obit  = dl[0];
  wire byte_done = shout && bcnt == 3'd7;
  wire [7:0]  new_byte = {obit, acc};
  wire [15:0] crc_nx = {1'b0, crc[15:1]} ^ ((crc[0] ^ obit) ? POLY_R : 16'h0000);

  wire long_enough = nbytes == 3'd4;
  wire close_wr  = flag && in_frame && long_enough;
  wire close_bad = (bcnt != 3'd0) || (crc != RESIDUE);
  wire abort_wr  = abrt && in_frame && long_enough;
  wire data_wr   = byte_done && nbytes >= 3'd3;
  wire wr_req    = data_wr || close_wr || abort_wr;
  wire [9:0] wr_entry = {close_wr || abort_wr, abort_wr || (close_wr && close_bad), h0};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ones <= '0; fill <= '0; bcnt <= '0; nbytes <= '0;
      in_frame <= 1'b0; drop <= 1'b0;
      dl <= '0; acc <= '0; crc <= '1;
      h0 <= '0; h1 <= '0; h2 <= '0;
    end else if (tap) begin
      ones <= line_bit ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;
      if (flag) begin
        in_frame <= 1'b1;
        fill <= '0; bcnt <= '0; nbytes <= '0;
        crc <= '1; drop <= 1'b0;
      end else if (abrt) begin
        in_frame <= 1'b0;
      end else if (dbit) begin
        dl <= {line_bit, dl[6:1]};
        if (fill != 3'd7) fill <= fill + 3'd1;
        if (shout) begin
          acc  <= new_byte[7:1];
          bcnt <= bcnt + 3'd1;
          crc  <= crc_nx;
        end
        if (byte_done) begin
          h0 <= h1; h1 <= h2; h2 <= new_byte;
          if (nbytes != 3'd4) nbytes <= nbytes + 3'd1;
        end
      end
      if (wr_req && fifo_full) drop <= 1'b1;
    end

  // receive FIFO
  logic [9:0] mem [DEPTH];
  logic [AW:0] wp, rp;
  wire wr_ok  = wr_req && !fifo_full && !drop;
  wire ovf    = wr_req && fifo_full && !drop;
  wire rd_ok  = rd_pop && !fifo_empty;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp[AW-1:0]] <= wr_entry;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
    end

  assign avail      = wp - rp;
  assign fifo_empty = wp == rp;
  assign fifo_full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign {rd_last, rd_bad, rd_data} = mem[rp[AW-1:0]];
  assign rx_active  = in_frame;

  // events
  wire [3:0] ev_set = {ovf, abrt && in_frame, close_wr && close_bad, close_wr && !close_bad};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev_status <= '0;
    else        ev_status <= (ev_status & ~ev_clear) | ev_set;

  assign irq = |(ev_status & ev_int_en);
endmodule

// File: rtl/hdlc_slot_rx_chk.sv
module hdlc_slot_rx_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic [AW:0] avail,
  input logic        fifo_empty,
  input logic        fifo_full,
  input logic        rx_active,
  input logic [3:0]  ev_status,
  input logic [3:0]  ev_clear,
  input logic [3:0]  ev_int_en,
  input logic        irq
);
  assert_avail_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    avail <= (AW+1)'(DEPTH));

  assert_not_empty_and_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_empty && fifo_full));

  assert_avail_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (avail == $past(avail)) || (avail == $past(avail) + 1'b1) || ($past(avail) == avail + 1'b1));

  assert_events_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_status & $past(ev_status) & ~$past(ev_clear)) == ($past(ev_status) & ~$past(ev_clear))));

  assert_irq_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_int_en == 4'b0000) |-> !irq);

  assert_abort_leaves_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_status[2]) |-> !rx_active);
endmodule

bind hdlc_slot_rx hdlc_slot_rx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .avail(avail), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .rx_active(rx_active), .ev_status(ev_status),
  .ev_clear(ev_clear), .ev_int_en(ev_int_en), .irq(irq)
);

// File: tb/hdlc_slot_rx_tb_top.sv
`timescale 1ns/1ps
module hdlc_slot_rx_tb_top;
  localparam int NUM_SLOTS = 32;
  localparam int DEPTH     = 64;
  localparam int LINE_BITS = NUM_SLOTS * 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, line_en = 1'b0, line_sync = 1'b0, line_bit = 1'b0;
  logic [4:0] cfg_slot = '0;
  logic [7:0] cfg_skip = '0;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_last, rd_bad, fifo_empty, fifo_full, rx_active, irq;
  logic [6:0] avail;
  logic [3:0] ev_status, ev_clear = '0, ev_int_en = '0;

  hdlc_slot_rx #(.NUM_SLOTS(NUM_SLOTS), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .line_sync(line_sync),
    .line_bit(line_bit), .cfg_slot(cfg_slot), .cfg_skip(cfg_skip),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_last(rd_last), .rd_bad(rd_bad),
    .avail(avail), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .rx_active(rx_active), .ev_status(ev_status), .ev_clear(ev_clear),
    .ev_int_en(ev_int_en), .irq(irq));

  int checks = 0, fails = 0, pos = 0, ones_tx = 0;
  bit finished = 1'b0;

  // {skip[55:48], slot[47:40], len[39:32], payload bytes, first in [7:0]}
  localparam logic [55:0] VEC [5] = '{
    {8'h00, 8'd1,  8'd2, 32'h0000_A55A},   // R1 R2 full slot
    {8'hF0, 8'd5,  8'd3, 32'h007E_FF01},   // R3 flag and all-ones payload
    {8'h7F, 8'd31, 8'd2, 32'h0000_3E7C},   // R1 single bit position
    {8'h5A, 8'd0,  8'd4, 32'hF81F_FFFE},   // R3 long runs of ones
    {8'h01, 8'd17, 8'd4, 32'h1234_5678}    // R5 four payload bytes
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_hbit(input logic b);
    bit done = 1'b0;
    while (!done) begin
      @(negedge clk);
      line_en   = 1'b1;
      line_sync = (pos == 0);
      if ((pos / 8) == int'(cfg_slot) && !cfg_skip[pos % 8]) begin
        line_bit = b;
        done = 1'b1;
      end else
        line_bit = ((pos ^ (pos >> 3)) & 1) != 0;
      pos = (pos + 1) % LINE_BITS;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      line_en = 1'b0;
      line_sync = 1'b0;
    end
  endtask

  task automatic send_dbit(input logic b);
    send_hbit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin
        send_hbit(1'b0);
        ones_tx = 0;
      end
    end else ones_tx = 0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_dbit(v[i]);
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_hbit(i != 0 && i != 7);
    ones_tx = 0;
  endtask

  task automatic send_abort();
    for (int i = 0; i < 8; i++) send_hbit(1'b1);
    ones_tx = 0;
  endtask

  task automatic send_frame(input logic [7:0] d[$], input bit corrupt);
    logic [15:0] c = 16'hFFFF;
    foreach (d[j]) begin
      send_byte(d[j]);
      for (int i = 0; i < 8; i++)
        c = (c[0] ^ d[j][i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    c = ~c;
    if (corrupt) c[3] = ~c[3];
    send_byte(c[7:0]);
    send_byte(c[15:8]);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d, input bit last, input bit bad);
    chk(req, "rd_data", rd_data, d);
    chk(req, "rd_last", rd_last, last);
    chk(req, "rd_bad", rd_bad, bad);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic clear_events();
    ev_clear = 4'hF;
    @(negedge clk);
    ev_clear = 4'h0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] q[$];
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "avail", avail, 0);
    chk("R11", "fifo_empty", fifo_empty, 1);
    chk("R11", "ev_status", ev_status, 0);
    chk("R11", "irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "rx_active", rx_active, 0);
    chk("R11", "fifo_full", fifo_full, 0);

    // table walk: R1 R2 R3 R5
    for (int k = 0; k < 5; k++) begin
      int n;
      cfg_skip = VEC[k][55:48];
      cfg_slot = VEC[k][44:40];
      n = int'(VEC[k][39:32]);
      q.delete();
      for (int i = 0; i < n; i++) q.push_back(VEC[k][8*i +: 8]);
      send_flag();
      send_flag();
      send_frame(q, 1'b0);
      send_flag();
      idle(3);
      chk("R5", "avail", avail, n);
      chk("R5", "ev_status", ev_status, 4'b0001);
      chk("R2", "rx_active", rx_active, 1);
      for (int i = 0; i < n; i++) pop_expect("R1", q[i], i == n - 1, 1'b0);
      chk("R8", "fifo_empty", fifo_empty, 1);
      clear_events();
    end

    // R6 corrupted check sequence
    cfg_slot = 5'd2; cfg_skip = 8'h00;
    q = '{8'h11, 8'h22, 8'h33};
    send_flag(); send_frame(q, 1'b1); send_flag(); idle(3);
    chk("R6", "avail", avail, 3);
    chk("R6", "ev_status", ev_status, 4'b0010);
    pop_expect("R6", 8'h11, 0, 0);
    pop_expect("R6", 8'h22, 0, 0);
    pop_expect("R6", 8'h33, 1, 1);
    clear_events();

    // R6 length not a whole number of bytes
    q = '{8'h44, 8'h55};
    send_flag(); send_frame(q, 1'b0);
    send_dbit(1'b0); send_dbit(1'b1); send_dbit(1'b0);
    send_flag(); idle(3);
    chk("R6", "avail misaligned", avail, 2);
    chk("R6", "ev_status misaligned", ev_status, 4'b0010);
    pop_expect("R6", 8'h44, 0, 0);
    pop_expect("R6", 8'h55, 1, 1);
    clear_events();

    // R7 runt frame of three bytes
    send_flag();
    send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
    send_flag(); idle(3);
    chk("R7", "avail", avail, 0);
    chk("R7", "ev_status", ev_status, 0);

    // R4 abort after six bytes: last byte still in the look-behind
    send_flag();
    for (int i = 1; i <= 6; i++) send_byte(8'(i));
    send_abort(); idle(3);
    chk("R4", "ev_status", ev_status, 4'b0100);
    chk("R4", "rx_active", rx_active, 0);
    chk("R4", "avail", avail, 3);
    pop_expect("R4", 8'h01, 0, 0);
    pop_expect("R4", 8'h02, 0, 0);
    pop_expect("R4", 8'h03, 1, 1);
    send_flag(); idle(2);
    chk("R4", "rx_active after flag", rx_active, 1);
    clear_events();

    // R9 overrun with a 70-byte payload
    cfg_slot = 5'd3;
    q.delete();
    for (int i = 0; i < 70; i++) q.push_back(8'(i));
    send_flag(); send_frame(q, 1'b0); send_flag(); idle(3);
    chk("R9", "ev_status", ev_status, 4'b1001);
    chk("R9", "avail", avail, DEPTH);
    chk("R8", "fifo_full", fifo_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8", "avail while draining", avail, DEPTH - i);
      pop_expect("R9", 8'(i), 0, 0);
    end
    chk("R9", "avail after drain", avail, 0);
    chk("R9", "overrun still set", ev_status[3], 1);

    // R10 interrupt enables and write-one clear
    ev_int_en = 4'b0000; @(negedge clk);
    chk("R10", "irq disabled", irq, 0);
    ev_int_en = 4'b0100; @(negedge clk);
    chk("R10", "irq abort only", irq, 0);
    ev_int_en = 4'b1000; @(negedge clk);
    chk("R10", "irq overrun", irq, 1);
    ev_clear = 4'b1000; @(negedge clk); ev_clear = 4'b0000;
    @(negedge clk);
    chk("R10", "ev_status after clear", ev_status, 4'b0001);
    chk("R10", "irq after clear", irq, 0);
    ev_int_en = 4'b0001; @(negedge clk);
    chk("R10", "irq good end", irq, 1);
    clear_events();
    chk("R10", "ev_status cleared", ev_status, 0);

    summary();
  end
endmodule